// File: doc/BRIEF.md
# Real-Time Clock Indexed Register Port

This block is the bus-facing front of a real-time clock. A byte-wide bus sees two addresses. The even address holds a 7-bit pointer. The odd address reads or writes the byte the pointer selects. Behind the port is a 128-location byte store. Four of those locations are control registers with their own behaviour: a rate/divider register, a mode/enable register, an interrupt-status register and a fixed status register. The rest are plain storage for time fields and general scratch bytes.

The timekeeping logic outside this block does three things. It pulses a flag input when a periodic tick, an alarm match or an update-ended event occurs. It raises a window signal during the short stretch just before each once-per-second update. It reads the control fields this block drives. The block turns these pieces into register contents and a single interrupt line. Reading the status register clears it. Writing the enable register can raise the interrupt at once. A legacy second location for the century byte is folded onto the primary one.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address stores data bits 6:0 as the pointer, and bit 7 is dropped. A read of the even address returns 0xFF.
- R2: Through the odd address, any location other than the four control registers (pointer 0x0A to 0x0D) and the legacy century location reads back the last byte written to it.
- R3: A read of the status register (pointer 0x0C) returns its current value. After that read the whole register is zero and the interrupt output is low.
- R4: Writes to the status register (0x0C) and to the fixed status register (0x0D) have no effect on the value read back.
- R5: Bit 7 of the rate/divider register (0x0A) is the update-in-progress bit and cannot be written. A write stores data bits 6:0 only.
- R6: A write to the mode register (0x0B) with bit 7 (freeze) set stores bit 4 (update-event enable) as 0 and clears the update-in-progress bit.
- R7: When a write to the mode register enables a flag that is already set in the status register, bit 7 of the status register and the interrupt output go high in the next cycle. When the write leaves no set flag enabled, both go low.
- R8: After reset the four control registers read 0x26, 0x02, 0x00 and 0x80, and the interrupt output is low.
- R9: The update-in-progress bit reads 1 one cycle after the update window input is high, but only while the clock runs. The clock runs while mode bit 7 is 0 and rate/divider bits 6:4 are at most 2.
- R10: A data access with the pointer at 0x37 reaches location 0x32 instead and rewrites the pointer to 0x32.
- R11: Status bits 6, 5 and 4 are set by the periodic, alarm and update-ended pulses. Bit 7 and the interrupt output are high whenever one of them is set together with the mode bit in the same position.
- R12: A flag pulse that arrives in the same cycle as a read of the status register is kept. The following read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWr | input | 1 | 1 for write, 0 for read |
| busAddr | input | 1 | 0 selects the pointer, 1 selects the data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle of a read access |
| periodicHit | input | 1 | Periodic tick pulse |
| alarmHit | input | 1 | Alarm match pulse |
| updateHit | input | 1 | Update-ended pulse |
| uipWindow | input | 1 | High in the window before a once-per-second update |
| irqOut | output | 1 | Interrupt request, active high |
| ctrlA | output | 7 | Rate/divider register bits 6:0 |
| ctrlB | output | 8 | Mode/enable register |

## Verification
The hardest case to reach from the ports is a flag pulse landing in exactly the cycle that reads the status register. The read must return the old value, and the new flag must survive the clear. The bench drives the pulse and the read access on the same falling edge, then reads twice more to see the flag once and then gone. The update-in-progress bit is also checked with the window input held high while the freeze bit or the divider field stops the clock.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
  localparam int IDX_W  = 7;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << IDX_W;

  localparam logic [IDX_W-1:0] IDX_A = 7'h0A;
  localparam logic [IDX_W-1:0] IDX_B = 7'h0B;
  localparam logic [IDX_W-1:0] IDX_C = 7'h0C;
  localparam logic [IDX_W-1:0] IDX_D = 7'h0D;

  localparam logic [DATA_W-1:0] RST_A = 8'h26;
  localparam logic [DATA_W-1:0] RST_B = 8'h02;
  localparam logic [DATA_W-1:0] VAL_D = 8'h80;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_LSB  = 4;

  typedef enum logic [2:0] {
    SEL_MEM,
    SEL_A,
    SEL_B,
    SEL_C,
    SEL_D
  } regSel_e;

  typedef struct packed {
    logic              rdIdxPort;
    logic              rdData;
    logic              wrA;
    logic              wrB;
    logic              wrMem;
    logic              rdC;
    regSel_e           sel;
    logic [IDX_W-1:0]  memAddr;
  } portStrobe_t;
endpackage

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
  import rtc_regport_pkg::*;
#(
  parameter logic [IDX_W-1:0] CENT_IDX     = 7'h32,
  parameter logic [IDX_W-1:0] ALT_CENT_IDX = 7'h37
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic [IDX_W-1:0] busWidx,
  output portStrobe_t      strobe,
  output logic [IDX_W-1:0] curIndex
);
  logic [IDX_W-1:0] indexReg;
  logic [IDX_W-1:0] effIdx;
  logic             dataAcc;
  logic             isAlias;

  assign isAlias = (indexReg == ALT_CENT_IDX);
  assign effIdx  = isAlias ? CENT_IDX : indexReg;
  assign dataAcc = busSel && busAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      indexReg <= '0;
    end else if (busSel && busWr && !busAddr) begin
      indexReg <= busWidx;
    end else if (dataAcc && isAlias) begin
      indexReg <= CENT_IDX;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.memAddr   = effIdx;
    strobe.rdIdxPort = busSel && !busWr && !busAddr;
    strobe.rdData    = dataAcc && !busWr;
    unique case (effIdx)
      IDX_A:   strobe.sel = SEL_A;
      IDX_B:   strobe.sel = SEL_B;
      IDX_C:   strobe.sel = SEL_C;
      IDX_D:   strobe.sel = SEL_D;
      default: strobe.sel = SEL_MEM;
    endcase
    strobe.wrA   = dataAcc && busWr && (strobe.sel == SEL_A);
    strobe.wrB   = dataAcc && busWr && (strobe.sel == SEL_B);
    strobe.wrMem = dataAcc && busWr && (strobe.sel == SEL_MEM);
    strobe.rdC   = strobe.rdData && (strobe.sel == SEL_C);
  end

  assign curIndex = indexReg;
endmodule

// File: rtl/rtc_port_dp.sv
module rtc_port_dp
  import rtc_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  portStrobe_t       strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_FLAGS-1:0] flagHits,
  input  logic              uipWindow,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [DATA_W-2:0] ctrlA,
  output logic [DATA_W-1:0] ctrlB,
  output logic [DATA_W-1:0] regCView,
  output logic              uipNow
);
  localparam logic [DATA_W-1:0] FREEZE_BIT = 8'h80;
  localparam logic [DATA_W-1:0] UEN_MASK   = 8'h10;
  localparam logic [2:0]        MAX_RUN_DIV = 3'd2;

  logic [DATA_W-1:0] mem [0:DEPTH-1];
  logic [DATA_W-2:0] aLow, aNext;
  logic [DATA_W-1:0] bReg, bNext;
  logic [NUM_FLAGS-1:0] flags, flagsNext;
  logic              irqFlag, irqNext;
  logic              uipBit, uipNext;
  logic [DATA_W-1:0] regRead;

  always_ff @(posedge clk) begin
    if (strobe.wrMem) begin
      mem[strobe.memAddr] <= busWdata;
    end
  end

  always_comb begin
    aNext = strobe.wrA ? busWdata[DATA_W-2:0] : aLow;
    bNext = bReg;
    if (strobe.wrB) begin
      bNext = (busWdata & FREEZE_BIT) != '0 ? (busWdata & ~UEN_MASK) : busWdata;
    end
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    always_comb begin
      flagsNext[g] = (flags[g] && !strobe.rdC) || flagHits[g];
    end
  end

  always_comb begin
    irqNext = |(flagsNext & bNext[FLAG_LSB +: NUM_FLAGS]);
    uipNext = uipWindow && (bNext[DATA_W-1] == 1'b0) &&
              (aNext[DATA_W-2 -: 3] <= MAX_RUN_DIV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aLow    <= RST_A[DATA_W-2:0];
      bReg    <= RST_B;
      flags   <= '0;
      irqFlag <= 1'b0;
      uipBit  <= 1'b0;
    end else begin
      aLow    <= aNext;
      bReg    <= bNext;
      flags   <= flagsNext;
      irqFlag <= irqNext;
      uipBit  <= uipNext;
    end
  end

  assign regCView = {irqFlag, flags, {FLAG_LSB{1'b0}}};

  always_comb begin
    unique case (strobe.sel)
      SEL_A:   regRead = {uipBit, aLow};
      SEL_B:   regRead = bReg;
      SEL_C:   regRead = regCView;
      SEL_D:   regRead = VAL_D;
      default: regRead = mem[strobe.memAddr];
    endcase
    if (strobe.rdIdxPort) begin
      busRdata = '1;
    end else if (strobe.rdData) begin
      busRdata = regRead;
    end else begin
      busRdata = '0;
    end
  end

  assign irqOut = irqFlag;
  assign ctrlA  = aLow;
  assign ctrlB  = bReg;
  assign uipNow = uipBit;
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
  import rtc_regport_pkg::*;
#(
  parameter logic [IDX_W-1:0] CENT_IDX     = 7'h32,
  parameter logic [IDX_W-1:0] ALT_CENT_IDX = 7'h37
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              periodicHit,
  input  logic              alarmHit,
  input  logic              updateHit,
  input  logic              uipWindow,
  output logic              irqOut,
  output logic [DATA_W-2:0] ctrlA,
  output logic [DATA_W-1:0] ctrlB
);
  portStrobe_t      strobe;
  logic [IDX_W-1:0] curIndex;
  logic [DATA_W-1:0] regCView;
  logic             uipNow;

  rtc_port_ctrl #(
    .CENT_IDX    (CENT_IDX),
    .ALT_CENT_IDX(ALT_CENT_IDX)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .busSel  (busSel),
    .busWr   (busWr),
    .busAddr (busAddr),
    .busWidx (busWdata[IDX_W-1:0]),
    .strobe  (strobe),
    .curIndex(curIndex)
  );

  rtc_port_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .flagHits ({periodicHit, alarmHit, updateHit}),
    .uipWindow(uipWindow),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .ctrlA    (ctrlA),
    .ctrlB    (ctrlB),
    .regCView (regCView),
    .uipNow   (uipNow)
  );
endmodule

// File: rtl/rtc_regport_chk.sv
module rtc_regport_chk
  import rtc_regport_pkg::*;
#(
  parameter logic [IDX_W-1:0] CENT_IDX     = 7'h32,
  parameter logic [IDX_W-1:0] ALT_CENT_IDX = 7'h37
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic              busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              periodicHit,
  input logic              alarmHit,
  input logic              updateHit,
  input logic              irqOut,
  input logic [DATA_W-2:0] ctrlA,
  input logic [DATA_W-1:0] ctrlB,
  input logic [IDX_W-1:0]  curIndex,
  input logic [DATA_W-1:0] regCView,
  input logic              uipNow
);
  logic anyHit, dataWr, dataRd;
  assign anyHit = periodicHit || alarmHit || updateHit;
  assign dataWr = busSel && busWr && busAddr;
  assign dataRd = busSel && !busWr && busAddr;

  // R1
  idx_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && !busAddr) |=> (curIndex == $past(busWdata[IDX_W-1:0])));

  // R3
  c_read_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && curIndex == IDX_C && !anyHit) |=> (!irqOut && regCView == '0));

  // R5
  a_write_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && curIndex == IDX_A) |=> (ctrlA == $past(busWdata[DATA_W-2:0])));

  // R6
  freeze_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && curIndex == IDX_B && busWdata[7]) |=> (!ctrlB[4] && ctrlB[7] && !uipNow));

  // R7
  enable_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataWr && curIndex == IDX_B && ((busWdata[6:5] & regCView[6:5]) != 2'b00)) |=> irqOut);

  // R10
  century_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busAddr && curIndex == ALT_CENT_IDX) |=> (curIndex == CENT_IDX));

  // R11
  update_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (updateHit && ctrlB[4] && !busSel) |=> (irqOut && regCView[4]));
endmodule

bind rtc_regport rtc_regport_chk #(
  .CENT_IDX    (CENT_IDX),
  .ALT_CENT_IDX(ALT_CENT_IDX)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .periodicHit(periodicHit),
  .alarmHit   (alarmHit),
  .updateHit  (updateHit),
  .irqOut     (irqOut),
  .ctrlA      (ctrlA),
  .ctrlB      (ctrlB),
  .curIndex   (curIndex),
  .regCView   (regCView),
  .uipNow     (uipNow)
);

// File: tb/rtc_regport_bench.sv
module rtc_regport_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic       busAddr = 1'b0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       periodicHit = 1'b0;
  logic       alarmHit = 1'b0;
  logic       updateHit = 1'b0;
  logic       uipWindow = 1'b0;
  logic       irqOut;
  logic [6:0] ctrlA;
  logic [7:0] ctrlB;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  rtc_regport u_rtc_regport (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .periodicHit(periodicHit),
    .alarmHit(alarmHit), .updateHit(updateHit), .uipWindow(uipWindow),
    .irqOut(irqOut), .ctrlA(ctrlA), .ctrlB(ctrlB)
  );

  // Monitor: compares every read against the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (busSel && !busWr) begin
        nChecks++;
        if (expQ.size() == 0) begin
          nFails++;
          $display("FAIL unexpected read got %02h exp none", busRdata);
        end else begin
          automatic logic [7:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          if (busRdata !== e) begin
            nFails++;
            $display("FAIL %s got %02h exp %02h", t, busRdata, e);
          end
        end
      end
    end
  end

  task automatic busOp(input logic wr, input logic addr, input logic [7:0] d,
                       input logic [7:0] e, input string t);
    @(negedge clk);
    {periodicHit, alarmHit, updateHit} = 3'b000;
    busSel = 1'b1; busWr = wr; busAddr = addr; busWdata = d;
    if (!wr) begin
      expQ.push_back(e);
      tagQ.push_back(t);
    end
  endtask

  task automatic wrIdx(input logic [7:0] i);
    busOp(1'b1, 1'b0, i, 8'h00, "");
  endtask
  task automatic wrData(input logic [7:0] d);
    busOp(1'b1, 1'b1, d, 8'h00, "");
  endtask
  task automatic rdData(input logic [7:0] e, input string t);
    busOp(1'b0, 1'b1, 8'h00, e, t);
  endtask
  task automatic setReg(input logic [7:0] i, input logic [7:0] d);
    wrIdx(i); wrData(d);
  endtask
  task automatic getReg(input logic [7:0] i, input logic [7:0] e, input string t);
    wrIdx(i); rdData(e, t);
  endtask

  task automatic checkIrq(input logic e, input string t);
    @(negedge clk);
    busSel = 1'b0;
    {periodicHit, alarmHit, updateHit} = 3'b000;
    #5;
    nChecks++;
    if (irqOut !== e) begin
      nFails++;
      $display("FAIL %s irqOut got %0b exp %0b", t, irqOut, e);
    end
  endtask

  task automatic pulse(input logic [2:0] which);
    @(negedge clk);
    busSel = 1'b0;
    {periodicHit, alarmHit, updateHit} = which;
    @(negedge clk);
    {periodicHit, alarmHit, updateHit} = 3'b000;
  endtask

  task automatic setUip(input logic v);
    @(negedge clk);
    busSel = 1'b0;
    uipWindow = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8 reset values
    checkIrq(1'b0, "R8 irq after reset");
    getReg(8'h0A, 8'h26, "R8 reg A");
    getReg(8'h0B, 8'h02, "R8 reg B");
    getReg(8'h0C, 8'h00, "R8 reg C");
    getReg(8'h0D, 8'h80, "R8 reg D");

    // R1 pointer capture drops bit 7, even read is 0xFF
    wrIdx(8'h95);
    wrData(8'h5A);
    busOp(1'b0, 1'b0, 8'h00, 8'hFF, "R1 even read");
    getReg(8'h15, 8'h5A, "R1 pointer low bits");

    // R2 plain storage
    setReg(8'h20, 8'h11);
    setReg(8'h7F, 8'hEE);
    setReg(8'h00, 8'h3C);
    getReg(8'h20, 8'h11, "R2 loc 20");
    getReg(8'h7F, 8'hEE, "R2 loc 7F");
    getReg(8'h00, 8'h3C, "R2 loc 00");

    // R4 C and D not writable
    setReg(8'h0C, 8'hFF);
    rdData(8'h00, "R4 C write ignored");
    checkIrq(1'b0, "R4 no irq from C write");
    setReg(8'h0D, 8'h00);
    rdData(8'h80, "R4 D write ignored");

    // R5 and R9 update-in-progress bit
    setReg(8'h0A, 8'hA5);
    rdData(8'h25, "R5 bit7 not writable");
    setUip(1'b1);
    rdData(8'hA5, "R9 uip while running");
    wrData(8'h70);
    rdData(8'h70, "R9 uip off when divider stopped");
    wrData(8'h26);
    rdData(8'hA6, "R9 uip back when running");

    // R6 freeze write
    setReg(8'h0B, 8'h92);
    rdData(8'h82, "R6 update enable forced low");
    getReg(8'h0A, 8'h26, "R6 uip cleared by freeze");
    setReg(8'h0B, 8'h02);
    setUip(1'b0);

    // R11 flag set without enable, then R3 read clear
    pulse(3'b001);
    checkIrq(1'b0, "R11 update flag not enabled");
    getReg(8'h0C, 8'h10, "R11 update flag bit4");
    rdData(8'h00, "R3 C cleared after read");

    // R11 with periodic enable, R3 clears irq
    setReg(8'h0B, 8'h42);
    pulse(3'b100);
    checkIrq(1'b1, "R11 periodic irq");
    getReg(8'h0C, 8'hC0, "R11 periodic flag and master");
    checkIrq(1'b0, "R3 irq low after C read");

    // R7 enable after flag already set
    setReg(8'h0B, 8'h02);
    pulse(3'b010);
    checkIrq(1'b0, "R7 alarm not yet enabled");
    setReg(8'h0B, 8'h42);
    checkIrq(1'b0, "R7 other enable no irq");
    setReg(8'h0B, 8'h22);
    checkIrq(1'b1, "R7 immediate irq on enable");
    setReg(8'h0B, 8'h02);
    checkIrq(1'b0, "R7 irq dropped on disable");
    getReg(8'h0C, 8'h20, "R7 flag kept master clear");

    // R12 flag arriving with C read
    wrIdx(8'h0C);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = 1'b1; updateHit = 1'b1;
    expQ.push_back(8'h00);
    tagQ.push_back("R12 read returns old value");
    rdData(8'h10, "R12 flag survives clear");
    rdData(8'h00, "R12 flag then cleared");

    // R10 century alias
    setReg(8'h37, 8'h19);
    getReg(8'h32, 8'h19, "R10 alias write lands at 32");
    setReg(8'h32, 8'h20);
    getReg(8'h37, 8'h20, "R10 alias read from 32");

    @(negedge clk);
    busSel = 1'b0;
    repeat (3) @(negedge clk);
    nChecks++;
    if (expQ.size() != 0) begin
      nFails++;
      $display("FAIL scoreboard left %0d exp 0", expQ.size());
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog expired got timeout exp completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule